// File: doc/BRIEF.md
# Packet-Gated Transmit Buffer with Cut-Through

This block sits between a 64-bit streaming source and a 10G MAC transmitter. It stores each incoming word together with its 4-bit sideband and its end marker. It holds the MAC side idle until a whole frame is in storage, so a frame that has started can never run dry halfway through. The sideband carries a start-of-frame flag in bit 3 and, in bits 2:0, the count of valid bytes in the closing word.

A parameter `CUT_THRESH` selects early release. When it is zero, storage holds 1024 words, which is enough for the longest frame, and only complete frames are released. When it is a positive N, storage shrinks to 2^(ceil(log2 N)+1) words. A frame then starts to leave as soon as more than N words are buffered, and the early-release state stays latched until that frame's end word has gone. The MAC has no back-pressure: whenever the gate is open and storage is not empty, one word leaves per clock.

Top module: `tx_pkt_gate`

## Requirements
- R1: While rst_ni is low and right after it rises, s_tready_o is 1, occupancy_o is 0 and mac_valid_o, mac_sof_o and mac_eof_o are 0.
- R2: Words leave in the order they were accepted. mac_data_o carries the 64 data bits and mac_occ_o carries sideband bits 2:0. mac_sof_o is sideband bit 3 and mac_eof_o is the end marker, and both are 0 whenever mac_valid_o is 0.
- R3: With CUT_THRESH = 0, mac_valid_o stays 0 until the clock edge that stores a frame's end word. The frame's first word is presented in the cycle that follows that edge.
- R4: While the gate is open and storage holds at least one word, mac_valid_o is 1 and one word is removed at every clock edge.
- R5: The count of complete frames rises on each stored end word and falls on each released end word. When both happen at the same edge, the count is unchanged, so a queued complete frame follows the outgoing one with no idle cycle.
- R6: With CUT_THRESH = N > 0, the early-release state sets at any edge where occupancy before the edge exceeds N. It clears at an edge that releases a valid end word, but setting wins over clearing, and reset clears it. While the state is set, words are released even if no complete frame is stored.
- R7: Once a frame's first word has been released, each following cycle in which storage is not empty releases a word, until the frame's end word leaves.
- R8: Storage holds 1024 words when CUT_THRESH = 0, and 2^(ceil(log2 N)+1) words otherwise. s_tready_o is 0 exactly when storage is full, and a word offered while full is not stored.
- R9: occupancy_o is the 16-bit number of stored words. At each edge it changes by accepted words minus released words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | 64 | Input word data |
| s_tuser_i | input | 4 | Input sideband: bit 3 start of frame, bits 2:0 byte count of the closing word |
| s_tlast_i | input | 1 | Input end-of-frame marker |
| s_tvalid_i | input | 1 | Input word valid |
| s_tready_o | output | 1 | Storage can accept a word |
| mac_data_o | output | 64 | Word data toward the MAC |
| mac_occ_o | output | 3 | Valid byte count of the closing word |
| mac_sof_o | output | 1 | First word of a frame |
| mac_eof_o | output | 1 | Last word of a frame |
| mac_valid_o | output | 1 | Word valid toward the MAC |
| occupancy_o | output | 16 | Number of stored words |

## Verification
Every MAC-side output and occupancy_o depends only on registered state. Each of them therefore reflects an edge's pushes and pops in the cycle right after that edge. The one exception is the early-release state, which responds one edge after occupancy first exceeds N. The bench keeps a per-cycle model of storage, complete-frame count and early-release state. It compares the outputs at every falling edge before it applies the next stimulus, and it advances the model by what the coming rising edge must do. The bench sweeps frame lengths 1 to 12 with gaps of 0 to 3 cycles, in both modes side by side. It also fills the 1024-word store with an unfinished frame to exercise the full and deadlock corner.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;
  localparam int DATA_W  = 64;
  localparam int USER_W  = 4;
  localparam int OCC_W   = 16;
  localparam int SOF_BIT = USER_W - 1;

  typedef struct packed {
    logic              last;
    logic [USER_W-1:0] user;
    logic [DATA_W-1:0] data;
  } tx_word_t;
endpackage

// File: rtl/tx_gate_store.sv
module tx_gate_store
  import tx_gate_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  tx_word_t         wdata_i,
  input  logic             pop_i,
  output tx_word_t         rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [OCC_W-1:0] occ_o
);
  localparam int DEPTH = 1 << AW;

  tx_word_t   mem_q [DEPTH];
  logic [AW:0] wr_q, rd_q, level;

  assign level   = wr_q - rd_q;
  assign full_o  = level[AW];
  assign empty_o = (level == '0);
  assign occ_o   = OCC_W'(level);
  assign rdata_o = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/tx_gate_pkt_cnt.sv
module tx_gate_pkt_cnt #(
  parameter int CW = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic avail_o
);
  logic [CW-1:0] cnt_q;

  assign avail_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (inc_i != dec_i)  cnt_q <= inc_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end
endmodule

// File: rtl/tx_gate_cut.sv
module tx_gate_cut
  import tx_gate_pkg::*;
#(
  parameter int THRESH = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OCC_W-1:0] occ_i,
  input  logic             eof_sent_i,
  output logic             on_o
);
  localparam bit ENABLE = (THRESH > 0);

  logic on_q, set;

  // constant-folds to 0 when early release is disabled
  assign set  = ENABLE && (occ_i > OCC_W'(THRESH));
  assign on_o = on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         on_q <= 1'b0;
    else if (set)        on_q <= 1'b1;
    else if (eof_sent_i) on_q <= 1'b0;
  end
endmodule

// File: rtl/tx_pkt_gate.sv
module tx_pkt_gate
  import tx_gate_pkg::*;
#(
  parameter int CUT_THRESH = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic [USER_W-1:0] s_tuser_i,
  input  logic              s_tlast_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  output logic [DATA_W-1:0] mac_data_o,
  output logic [USER_W-2:0] mac_occ_o,
  output logic              mac_sof_o,
  output logic              mac_eof_o,
  output logic              mac_valid_o,
  output logic [OCC_W-1:0]  occupancy_o
);
  localparam int AW    = (CUT_THRESH > 0) ? $clog2(CUT_THRESH) + 1 : 10;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  tx_word_t wr_word, head;
  logic     full, empty, push, pop, pkt_avail, cut_on, gate;

  assign wr_word = '{last: s_tlast_i, user: s_tuser_i, data: s_tdata_i};
  assign push    = s_tvalid_i & ~full;
  assign gate    = pkt_avail | cut_on;
  assign pop     = gate & ~empty;

  tx_gate_store #(.AW(AW)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wr_word),
    .pop_i   (pop),
    .rdata_o (head),
    .full_o  (full),
    .empty_o (empty),
    .occ_o   (occupancy_o)
  );

  tx_gate_pkt_cnt #(.CW(CW)) i_pkt_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (push & s_tlast_i),
    .dec_i   (pop & head.last),
    .avail_o (pkt_avail)
  );

  tx_gate_cut #(.THRESH(CUT_THRESH)) i_cut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .occ_i      (occupancy_o),
    .eof_sent_i (pop & head.last),
    .on_o       (cut_on)
  );

  assign s_tready_o  = ~full;
  assign mac_valid_o = pop;
  assign mac_sof_o   = pop & head.user[SOF_BIT];
  assign mac_eof_o   = pop & head.last;
  assign mac_data_o  = head.data;
  assign mac_occ_o   = head.user[USER_W-2:0];
endmodule

// File: rtl/tx_pkt_gate_chk.sv
module tx_pkt_gate_chk #(
  parameter int CUT_THRESH = 0,
  parameter int DEPTH      = 1024
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        s_tvalid_i,
  input logic        s_tlast_i,
  input logic        s_tready_o,
  input logic        mac_valid_o,
  input logic        mac_sof_o,
  input logic        mac_eof_o,
  input logic [15:0] occupancy_o
);
  logic        push, rel_eof;
  logic        in_frame_q;
  logic [15:0] occ_exp_q, done_q;

  assign push    = s_tvalid_i & s_tready_o;
  assign rel_eof = mac_valid_o & mac_eof_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      occ_exp_q  <= '0;
      done_q     <= '0;
    end else begin
      if (mac_valid_o) in_frame_q <= ~mac_eof_o;
      occ_exp_q <= occupancy_o + 16'(push) - 16'(mac_valid_o);
      done_q    <= done_q + 16'(push & s_tlast_i) - 16'(rel_eof);
    end
  end

  AST_MARKS_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_sof_o | mac_eof_o) |-> mac_valid_o); // R2

  AST_OCC_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occupancy_o == occ_exp_q); // R9

  AST_READY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_tready_o == (occupancy_o < 16'(DEPTH))); // R8

  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && occupancy_o != '0) |-> mac_valid_o); // R7

  if (CUT_THRESH == 0) begin : g_whole
    AST_NO_EARLY_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mac_valid_o |-> (done_q != '0)); // R3
  end else begin : g_cut
    AST_CUT_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(occupancy_o) > 16'(CUT_THRESH) && occupancy_o != '0) |-> mac_valid_o); // R6
  end
endmodule

bind tx_pkt_gate tx_pkt_gate_chk #(.CUT_THRESH(CUT_THRESH), .DEPTH(DEPTH)) i_tx_pkt_gate_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .s_tvalid_i  (s_tvalid_i),
  .s_tlast_i   (s_tlast_i),
  .s_tready_o  (s_tready_o),
  .mac_valid_o (mac_valid_o),
  .mac_sof_o   (mac_sof_o),
  .mac_eof_o   (mac_eof_o),
  .occupancy_o (occupancy_o)
);

// File: tb/test_tx_pkt_gate.sv
module test_tx_pkt_gate;
  localparam int CLK_P = 10;
  localparam int CUT_N = 3;
  localparam int WDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tdata = '0;
  logic [3:0]  tuser = '0;
  logic        tlast = 1'b0;
  logic [1:0]  vld = '0;
  logic [1:0]  tready, mv, msof, meof;
  logic [63:0] md [2];
  logic [2:0]  mocc [2];
  logic [15:0] occ [2];

  int n_chk = 0;
  int n_fail = 0;

  // model state per instance: 0 = whole-frame, 1 = early release
  logic [68:0] mq [2][1024];
  int mh [2], mt [2], mpk [2];
  bit mcut [2];

  always #(CLK_P/2) clk = ~clk;

  tx_pkt_gate i_tx_pkt_gate (
    .clk_i(clk), .rst_ni(rst_n), .s_tdata_i(tdata), .s_tuser_i(tuser),
    .s_tlast_i(tlast), .s_tvalid_i(vld[0]), .s_tready_o(tready[0]),
    .mac_data_o(md[0]), .mac_occ_o(mocc[0]), .mac_sof_o(msof[0]),
    .mac_eof_o(meof[0]), .mac_valid_o(mv[0]), .occupancy_o(occ[0])
  );

  tx_pkt_gate #(.CUT_THRESH(CUT_N)) i_tx_pkt_gate_ct (
    .clk_i(clk), .rst_ni(rst_n), .s_tdata_i(tdata), .s_tuser_i(tuser),
    .s_tlast_i(tlast), .s_tvalid_i(vld[1]), .s_tready_o(tready[1]),
    .mac_data_o(md[1]), .mac_occ_o(mocc[1]), .mac_sof_o(msof[1]),
    .mac_eof_o(meof[1]), .mac_valid_o(mv[1]), .occupancy_o(occ[1])
  );

  function automatic int depth_of(int d);
    return (d == 0) ? 1024 : 8;   // R8: 2^10, and 2^(ceil(log2 3)+1)
  endfunction

  function automatic int thr_of(int d);
    return (d == 0) ? 0 : CUT_N;
  endfunction

  // word = {last, sof, occ[2:0], data}
  function automatic logic [68:0] mk(int id, int k, int len);
    logic last;
    last = (k == len - 1);
    return {last, (k == 0), (last ? 3'(len) : 3'd0), 32'(id), 32'(k)};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      mh[d] = 0; mt[d] = 0; mpk[d] = 0; mcut[d] = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // called at a falling edge: check outputs, advance model for the next rising edge, drive
  task automatic step(input logic [1:0] v, input logic [68:0] w);
    int          sz;
    logic [68:0] hd;
    bit          ev, acc, ncut;
    for (int d = 0; d < 2; d++) begin
      sz = mt[d] - mh[d];
      hd = mq[d][mh[d] % 1024];
      ev = (mpk[d] > 0 || mcut[d]) && sz > 0;
      chk("R9", "occupancy", 64'(occ[d]), 64'(sz));
      chk("R8", "ready", 64'(tready[d]), 64'(sz < depth_of(d)));
      chk("R3 R4 R5 R6 R7", "valid", 64'(mv[d]), 64'(ev));
      chk("R2", "sof", 64'(msof[d]), 64'(ev && hd[67]));
      chk("R2", "eof", 64'(meof[d]), 64'(ev && hd[68]));
      if (ev) begin
        chk("R2", "data", md[d], hd[63:0]);
        chk("R2", "occ", 64'(mocc[d]), 64'(hd[66:64]));
      end
      acc  = v[d] && (sz < depth_of(d));
      ncut = (thr_of(d) > 0) && (sz > thr_of(d) || (mcut[d] && !(ev && hd[68])));
      if (ev) begin
        mh[d]++;
        if (hd[68]) mpk[d]--;
      end
      if (acc) begin
        mq[d][mt[d] % 1024] = w;
        mt[d]++;
        if (w[68]) mpk[d]++;
      end
      mcut[d] = ncut;
    end
    tdata = w[63:0];
    tuser = w[67:64];
    tlast = w[68];
    vld   = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_pkt(int id, int len, int gap);
    bit rdy;
    for (int k = 0; k < len; k++) begin
      do begin
        rdy = (mt[0] - mh[0] < 1024) && (mt[1] - mh[1] < 8);
        step(rdy ? 2'b11 : 2'b00, mk(id, k, len));
      end while (!rdy);
    end
    for (int g = 0; g < gap; g++) step(2'b00, '0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vld   = '0;
    #1;
    model_reset();
    for (int d = 0; d < 2; d++) begin
      chk("R1", "ready in reset", 64'(tready[d]), 64'd1);
      chk("R1", "occupancy in reset", 64'(occ[d]), 64'd0);
      chk("R1", "valid in reset", 64'(mv[d]), 64'd0);
      chk("R1", "sof/eof in reset", 64'({msof[d], meof[d]}), 64'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * WDOG);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int id;
    id = 1;
    repeat (3) @(negedge clk);
    do_reset();
    step(2'b00, '0);   // R1: idle right after release, checked inside step

    // R3 R6: frame-length and gap sweep in both modes
    for (int len = 1; len <= 12; len++) begin
      for (int gap = 0; gap <= 3; gap++) begin
        send_pkt(id, len, gap);
        id++;
      end
    end
    // R5 R6: back-to-back single-word and short frames
    for (int i = 0; i < 10; i++) begin
      send_pkt(id, 1 + (i % 3), 0);
      id++;
    end
    // R7: long frame with stalls in the middle (early release drains then waits)
    for (int k = 0; k < 9; k++) begin
      step(2'b11, mk(id, k, 9));
      if (k == 4) repeat (3) step(2'b00, '0);
    end
    id++;
    repeat (30) step(2'b00, '0);
    for (int d = 0; d < 2; d++) chk("R9", "drained", 64'(occ[d]), 64'd0);

    // R8: fill the whole-frame store with an unfinished frame
    do_reset();
    for (int k = 0; k < 1024; k++) step(2'b11, mk(id, k, 4000));
    chk("R8", "full occupancy", 64'(occ[0]), 64'd1024);
    chk("R8", "ready low when full", 64'(tready[0]), 64'd0);
    for (int i = 0; i < 5; i++) step(2'b11, mk(id + 1, 0, 1));
    chk("R8", "offered word ignored", 64'(occ[0]), 64'd1024);
    chk("R3", "no release without end word", 64'(mv[0]), 64'd0);
    step(2'b00, '0);

    do_reset();
    send_pkt(id + 2, 2, 4);
    finish_run();
  end
endmodule